// File: doc/BRIEF.md
# Adder-Completion Cycle Counter

This block keeps the cycle count for a core that has no fixed global clock. A cycle is one completed standard addition. While any hart has unretired work, the block keeps one throw-away addition running on a shared adder. The operands are always the same pair, and the sum is not used. Each completion of such an addition advances a double-word counter by one. The adders sit outside the block. Each one is reached through a request/acknowledge port with data-dependent latency, and the block's operand muxes put either the core's instruction operands or the fixed dummy pair onto it.

Instruction additions always take precedence over the dummy loop. With more than one adder, the dummy additions rotate over the adders in turn, so the load does not fall on a single unit. In that case an instruction addition that took an adder away from the dummy loop is also counted. When every hart is idle, no new dummy addition starts and the count holds. Software reads the count as a low word and a high word. Reading the high word captures the low word, so a high-then-low pair gives a consistent snapshot.

Top module: `adder_cycle_counter`

## Requirements
- R1: A dummy operation drives operands 0xDEADBEEF and 0xCAFEF00D, truncated to the low WORD_W bits, onto its adder. Every adder request, dummy or instruction, stays asserted with stable operands until its acknowledge.
- R2: Each dummy completion, seen as request and acknowledge high in the same cycle, raises the count by one at the next clock edge. With no completion the count holds.
- R3: An instruction request on an adder that is idle or acknowledging in that cycle is granted in that same cycle, and its request with the instruction operands shows from the next cycle on. A dummy add never starts on an adder whose instruction request is high.
- R4: While all hart activity inputs are low, no dummy addition is started. A dummy already in flight still completes. After that the count is frozen and the adder requests stay low.
- R5: At most one dummy addition is outstanding. Successive dummies go to adders 0, 1, …, N_ADDERS-1, 0, …, starting at adder 0 after reset. The next dummy can start in the same cycle the previous one completes.
- R6: With N_ADDERS > 1, an instruction addition granted in the completion cycle of a dummy on the same adder adds one to the count when it completes. An instruction addition granted on an idle adder, or after another instruction, adds nothing.
- R7: When several counted completions fall in one cycle, the count rises by their total number.
- R8: The count is 2*WORD_W bits wide, wraps modulo 2^(2*WORD_W), and is zero after reset.
- R9: A read (rd_en_i high) returns its word on rd_data_o in the next cycle: the high word when rd_hi_i=1, otherwise the low word. A high read captures the low word of that same moment. The next low read returns that captured value and then drops it. A low read with no capture pending returns the live low word.
- R10: ins_done_o pulses for the cycle in which an instruction addition is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hart_busy_i | input | N_HARTS | High per hart with unretired instructions |
| ins_req_i | input | N_ADDERS | Instruction addition wanted on each adder, held until granted |
| ins_a_i | input | N_ADDERS*WORD_W | Instruction operand A per adder |
| ins_b_i | input | N_ADDERS*WORD_W | Instruction operand B per adder |
| ins_gnt_o | output | N_ADDERS | Instruction request accepted this cycle |
| ins_done_o | output | N_ADDERS | Instruction addition completed this cycle |
| add_req_o | output | N_ADDERS | Request to each adder |
| add_a_o | output | N_ADDERS*WORD_W | Operand A to each adder |
| add_b_o | output | N_ADDERS*WORD_W | Operand B to each adder |
| add_ack_i | input | N_ADDERS | Adder completion acknowledge |
| rd_en_i | input | 1 | Read strobe |
| rd_hi_i | input | 1 | Read selects the high word |
| rd_data_o | output | WORD_W | Read data, one cycle after the strobe |

## Verification
The bench uses three adders and 4-bit words, which gives an 8-bit count. Adder latencies are set so that a displaced instruction and a rotated dummy complete in the same cycle. A design that handled only one completion per cycle would then lose a count. It also checks that rotation carries on through the instruction takeover and always stays on the next adder in turn. A pointer that stalled or skipped an adder would then be caught. It runs the count through its wrap and interleaves high-then-low reads while the low word is carrying. A read port without the low-word capture would then return torn values. Instructions issued while the harts are idle must leave the count at zero, which catches a design that counts every completion.

// File: rtl/adc_pkg.sv
package adc_pkg;
  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_DMY  = 2'd1,
    LN_INS  = 2'd2
  } lane_st_e;

  localparam logic [31:0] DMY_OP_A = 32'hDEADBEEF;
  localparam logic [31:0] DMY_OP_B = 32'hCAFEF00D;
endpackage

// File: rtl/adc_lane.sv
module adc_lane
  import adc_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter bit COUNT_DISP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_req_i,
  input  logic [WORD_W-1:0] ins_a_i,
  input  logic [WORD_W-1:0] ins_b_i,
  input  logic              dmy_try_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic              gnt_o,
  output logic              dmy_issue_o,
  output logic              dmy_busy_o,
  output logic              dmy_done_o,
  output logic              ins_done_o,
  output logic              disp_done_o
);
  lane_st_e          st_q, st_d;
  logic [WORD_W-1:0] a_q, b_q, a_d, b_d;
  logic              disp_q, disp_d;
  logic              free;

  // lane can take a new op in the cycle its current op is acknowledged
  assign free        = (st_q == LN_IDLE) | ack_i;
  assign gnt_o       = free & ins_req_i;
  assign dmy_issue_o = free & ~ins_req_i & dmy_try_i;
  assign dmy_done_o  = (st_q == LN_DMY) & ack_i;
  assign ins_done_o  = (st_q == LN_INS) & ack_i;
  assign disp_done_o = ins_done_o & disp_q;
  assign dmy_busy_o  = (st_q == LN_DMY);
  assign req_o       = (st_q != LN_IDLE);
  assign a_o         = a_q;
  assign b_o         = b_q;

  always_comb begin
    st_d   = st_q;
    a_d    = a_q;
    b_d    = b_q;
    disp_d = disp_q;
    if (free) begin
      if (ins_req_i) begin
        st_d   = LN_INS;
        a_d    = ins_a_i;
        b_d    = ins_b_i;
        disp_d = COUNT_DISP & dmy_done_o;
      end else if (dmy_try_i) begin
        st_d   = LN_DMY;
        a_d    = WORD_W'(DMY_OP_A);
        b_d    = WORD_W'(DMY_OP_B);
        disp_d = 1'b0;
      end else begin
        st_d   = LN_IDLE;
        disp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LN_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      disp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      a_q    <= a_d;
      b_q    <= b_d;
      disp_q <= disp_d;
    end
  end
endmodule

// File: rtl/adc_rr.sv
module adc_rr #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic [N-1:0] dmy_issue_i,
  input  logic [N-1:0] dmy_done_i,
  output logic [N-1:0] dmy_try_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic          pend_q, pend_n;

  // token freed in the completion cycle so the next dummy starts without a gap
  assign pend_n = pend_q & ~(|dmy_done_i);

  for (genvar k = 0; k < N; k++) begin : g_try
    assign dmy_try_o[k] = active_i & ~pend_n & (ptr_q == PW'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else if (|dmy_issue_i) begin
      ptr_q  <= (ptr_q == PW'(N - 1)) ? '0 : ptr_q + PW'(1);
      pend_q <= 1'b1;
    end else begin
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/adc_acc.sv
module adc_acc #(
  parameter int N      = 2,
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        dmy_done_i,
  input  logic [N-1:0]        disp_done_i,
  input  logic                rd_en_i,
  input  logic                rd_hi_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic [2*WORD_W-1:0] cnt_o
);
  localparam int CW = 2 * WORD_W;
  localparam int IW = $clog2(2 * N + 1);

  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     inc;
  logic [WORD_W-1:0] lo_cap_q;
  logic              lo_cap_v_q;

  always_comb begin
    inc = '0;
    for (int k = 0; k < N; k++) begin
      inc = inc + IW'(dmy_done_i[k]) + IW'(disp_done_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(inc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      lo_cap_q   <= '0;
      lo_cap_v_q <= 1'b0;
    end else if (rd_en_i) begin
      if (rd_hi_i) begin
        rd_data_o  <= cnt_q[CW-1:WORD_W];
        lo_cap_q   <= cnt_q[WORD_W-1:0];
        lo_cap_v_q <= 1'b1;
      end else begin
        rd_data_o  <= lo_cap_v_q ? lo_cap_q : cnt_q[WORD_W-1:0];
        lo_cap_v_q <= 1'b0;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adder_cycle_counter.sv
module adder_cycle_counter #(
  parameter int N_ADDERS = 2,
  parameter int N_HARTS  = 2,
  parameter int WORD_W   = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_HARTS-1:0]           hart_busy_i,
  input  logic [N_ADDERS-1:0]          ins_req_i,
  input  logic [N_ADDERS*WORD_W-1:0]   ins_a_i,
  input  logic [N_ADDERS*WORD_W-1:0]   ins_b_i,
  output logic [N_ADDERS-1:0]          ins_gnt_o,
  output logic [N_ADDERS-1:0]          ins_done_o,
  output logic [N_ADDERS-1:0]          add_req_o,
  output logic [N_ADDERS*WORD_W-1:0]   add_a_o,
  output logic [N_ADDERS*WORD_W-1:0]   add_b_o,
  input  logic [N_ADDERS-1:0]          add_ack_i,
  input  logic                         rd_en_i,
  input  logic                         rd_hi_i,
  output logic [WORD_W-1:0]            rd_data_o
);
  localparam bit MULTI = (N_ADDERS > 1);

  logic [N_ADDERS-1:0] dmy_try, dmy_issue, dmy_busy, dmy_done, disp_done;
  logic [2*WORD_W-1:0] cnt;
  logic                active;

  assign active = |hart_busy_i;

  for (genvar k = 0; k < N_ADDERS; k++) begin : g_lane
    adc_lane #(
      .WORD_W    (WORD_W),
      .COUNT_DISP(MULTI)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ins_req_i  (ins_req_i[k]),
      .ins_a_i    (ins_a_i[k*WORD_W +: WORD_W]),
      .ins_b_i    (ins_b_i[k*WORD_W +: WORD_W]),
      .dmy_try_i  (dmy_try[k]),
      .ack_i      (add_ack_i[k]),
      .req_o      (add_req_o[k]),
      .a_o        (add_a_o[k*WORD_W +: WORD_W]),
      .b_o        (add_b_o[k*WORD_W +: WORD_W]),
      .gnt_o      (ins_gnt_o[k]),
      .dmy_issue_o(dmy_issue[k]),
      .dmy_busy_o (dmy_busy[k]),
      .dmy_done_o (dmy_done[k]),
      .ins_done_o (ins_done_o[k]),
      .disp_done_o(disp_done[k])
    );
  end

  adc_rr #(.N(N_ADDERS)) u_rr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .dmy_issue_i(dmy_issue),
    .dmy_done_i (dmy_done),
    .dmy_try_o  (dmy_try)
  );

  adc_acc #(.N(N_ADDERS), .WORD_W(WORD_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dmy_done_i (dmy_done),
    .disp_done_i(disp_done),
    .rd_en_i    (rd_en_i),
    .rd_hi_i    (rd_hi_i),
    .rd_data_o  (rd_data_o),
    .cnt_o      (cnt)
  );
endmodule

// File: rtl/adc_checker.sv
module adc_checker #(
  parameter int N_ADDERS = 2,
  parameter int N_HARTS  = 2,
  parameter int WORD_W   = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_HARTS-1:0]         hart_busy_i,
  input logic [N_ADDERS-1:0]        ins_req_i,
  input logic [N_ADDERS-1:0]        ins_gnt_i,
  input logic [N_ADDERS-1:0]        add_req_i,
  input logic [N_ADDERS-1:0]        add_ack_i,
  input logic [N_ADDERS*WORD_W-1:0] add_a_i,
  input logic [N_ADDERS*WORD_W-1:0] add_b_i,
  input logic [2*WORD_W-1:0]        cnt_i,
  input logic [N_ADDERS-1:0]        dmy_busy_i
);
  localparam int CW = 2 * WORD_W;

  for (genvar k = 0; k < N_ADDERS; k++) begin : g_lane_chk
    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      add_req_i[k] && !add_ack_i[k] |=> add_req_i[k]); // R1
    AST_OPS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      add_req_i[k] && !add_ack_i[k] |=>
        $stable(add_a_i[k*WORD_W +: WORD_W]) && $stable(add_b_i[k*WORD_W +: WORD_W])); // R1
    AST_GNT_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ins_gnt_i[k] |=> add_req_i[k]); // R3
  end

  AST_GNT_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_gnt_i & add_req_i & ~add_ack_i) == '0); // R3
  AST_ONE_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dmy_busy_i) <= 1); // R5
  AST_IDLE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hart_busy_i) && !(|add_req_i) && !(|ins_req_i) |=> !(|add_req_i)); // R4
  AST_CNT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(add_req_i & add_ack_i)) |=> $stable(cnt_i)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(add_req_i & add_ack_i) |=> (CW'(cnt_i - $past(cnt_i)) <= CW'(N_ADDERS))); // R7
endmodule

bind adder_cycle_counter adc_checker #(
  .N_ADDERS(N_ADDERS),
  .N_HARTS (N_HARTS),
  .WORD_W  (WORD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hart_busy_i(hart_busy_i),
  .ins_req_i  (ins_req_i),
  .ins_gnt_i  (ins_gnt_o),
  .add_req_i  (add_req_o),
  .add_ack_i  (add_ack_i),
  .add_a_i    (add_a_o),
  .add_b_i    (add_b_o),
  .cnt_i      (cnt),
  .dmy_busy_i (dmy_busy)
);

// File: tb/adder_cycle_counter_tb.sv
module adder_cycle_counter_tb;
  localparam int NA = 3;
  localparam int NH = 2;
  localparam int WW = 4;
  localparam int CW = 2 * WW;
  localparam logic [WW-1:0] DA = 4'hF;
  localparam logic [WW-1:0] DB = 4'hD;
  localparam logic [WW-1:0] IA = 4'h3;
  localparam logic [WW-1:0] IB = 4'h5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NH-1:0]     hart_busy_i = '0;
  logic [NA-1:0]     ins_req_i = '0;
  logic [NA*WW-1:0]  ins_a_i = {NA{IA}};
  logic [NA*WW-1:0]  ins_b_i = {NA{IB}};
  logic [NA-1:0]     ins_gnt_o, ins_done_o, add_req_o;
  logic [NA*WW-1:0]  add_a_o, add_b_o;
  logic [NA-1:0]     add_ack_i;
  logic              rd_en_i = 1'b0;
  logic              rd_hi_i = 1'b0;
  logic [WW-1:0]     rd_data_o;

  always #2.5 clk_i = ~clk_i;

  adder_cycle_counter #(.N_ADDERS(NA), .N_HARTS(NH), .WORD_W(WW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hart_busy_i(hart_busy_i),
    .ins_req_i(ins_req_i), .ins_a_i(ins_a_i), .ins_b_i(ins_b_i),
    .ins_gnt_o(ins_gnt_o), .ins_done_o(ins_done_o),
    .add_req_o(add_req_o), .add_a_o(add_a_o), .add_b_o(add_b_o),
    .add_ack_i(add_ack_i), .rd_en_i(rd_en_i), .rd_hi_i(rd_hi_i),
    .rd_data_o(rd_data_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  function automatic void chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endfunction

  // adder model: acknowledge after lat[k] cycles of request
  int lat [NA];
  int wcnt[NA];
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_ack_i <= '0;
      for (int k = 0; k < NA; k++) wcnt[k] <= 0;
    end else begin
      for (int k = 0; k < NA; k++) begin
        if (add_req_o[k] && !add_ack_i[k]) begin
          if (wcnt[k] + 1 >= lat[k]) begin
            add_ack_i[k] <= 1'b1;
            wcnt[k]      <= 0;
          end else begin
            wcnt[k] <= wcnt[k] + 1;
          end
        end else begin
          add_ack_i[k] <= 1'b0;
        end
      end
    end
  end

  // reference model of the count, built from port activity
  logic [CW-1:0] exp_cnt;
  int            n_tot, n_dmy, n_disp, n_coinc, exp_ptr;
  logic [NA-1:0] req_p, ack_p, op_d, disp;
  always @(posedge clk_i) begin
    int inc;
    logic [WW-1:0] a, b;
    if (!rst_ni) begin
      exp_cnt = '0; n_tot = 0; exp_ptr = 0;
      req_p = '0; ack_p = '0; op_d = '0; disp = '0;
    end else begin
      inc = 0;
      for (int k = 0; k < NA; k++) begin
        a = add_a_o[k*WW +: WW];
        b = add_b_o[k*WW +: WW];
        if (add_req_o[k] && (!req_p[k] || ack_p[k])) begin
          if (a == DA) begin
            chk(b == DB, "R1 dummy operand B", b, DB);
            chk(k == exp_ptr, "R5 rotation order", k, exp_ptr);
            exp_ptr = (k + 1) % NA;
            op_d[k] = 1'b1;
          end else begin
            chk(a == IA && b == IB, "R3 instruction operands", a, IA);
            op_d[k] = 1'b0;
          end
        end
        if (add_req_o[k] && add_ack_i[k]) begin
          if (op_d[k]) begin inc++; n_dmy++; end
          else if (disp[k]) begin inc++; n_disp++; end
          disp[k] = op_d[k] && ins_gnt_o[k];
        end else if (ins_gnt_o[k]) begin
          disp[k] = 1'b0;
        end
      end
      if (inc > 1) n_coinc++;
      exp_cnt = exp_cnt + CW'(inc);
      n_tot   = n_tot + inc;
      req_p   = add_req_o;
      ack_p   = add_ack_i;
    end
  end

  task automatic rd(input bit hi, output logic [WW-1:0] d);
    rd_hi_i = hi;
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic check_count(input string rq, input logic [CW-1:0] e);
    logic [WW-1:0] lo, hi;
    rd(1'b1, hi);
    rd(1'b0, lo);
    chk({hi, lo} == e, rq, {hi, lo}, e);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog timeout", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [WW-1:0] d;
    logic [CW-1:0] snap;
    int base, found;
    n_dmy = 0; n_disp = 0; n_coinc = 0;
    for (int k = 0; k < NA; k++) lat[k] = 2;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8 reset state
    chk(add_req_o == '0, "R8 no requests after reset", add_req_o, 0);
    check_count("R8 count zero after reset", '0);

    // R4 idle: nothing issued, nothing counted
    repeat (20) @(negedge clk_i);
    chk(add_req_o == '0, "R4 idle no dummy", add_req_o, 0);
    check_count("R4 idle count frozen", '0);

    // R6 instruction on idle adder is not counted; R3 same-cycle grant; R10 done pulse
    ins_req_i[1] = 1'b1;
    #1;
    chk(ins_gnt_o[1], "R3 grant on free adder", ins_gnt_o[1], 1);
    @(negedge clk_i);
    ins_req_i[1] = 1'b0;
    found = 0;
    for (int i = 0; i < 10 && !found; i++) begin
      @(negedge clk_i);
      if (ins_done_o[1]) found = 1;
    end
    chk(found == 1, "R10 instruction done pulse", found, 1);
    repeat (3) @(negedge clk_i);
    check_count("R6 undisplaced instruction not counted", '0);

    // R2/R5 continuous dummy loop, latency 1 => one completion per two cycles
    for (int k = 0; k < NA; k++) lat[k] = 1;
    base = n_dmy;
    hart_busy_i = 2'b10;
    repeat (60) @(negedge clk_i);
    chk(n_dmy - base >= 28, "R5 back-to-back dummy rate", n_dmy - base, 28);
    hart_busy_i = '0;
    repeat (10) @(negedge clk_i);
    chk(add_req_o == '0, "R4 loop stops when idle", add_req_o, 0);
    check_count("R2 count equals dummy completions", exp_cnt);
    snap = exp_cnt;
    repeat (20) @(negedge clk_i);
    check_count("R4 count frozen while idle", snap);

    // R3/R6/R7 instruction displaces a dummy on adder 0
    lat[0] = 3; lat[1] = 1; lat[2] = 1;
    hart_busy_i = 2'b01;
    found = 0;
    for (int i = 0; i < 50 && !found; i++) begin
      @(negedge clk_i);
      if (add_req_o[0] && add_a_o[WW-1:0] == DA) found = 1;
    end
    chk(found == 1, "R5 dummy reaches adder 0", found, 1);
    ins_req_i[0] = 1'b1;
    found = 0;
    for (int i = 0; i < 10 && !found; i++) begin
      @(negedge clk_i);
      if (ins_gnt_o[0]) begin
        found = 1;
        chk(add_ack_i[0], "R3 grant in dummy completion cycle", add_ack_i[0], 1);
      end
    end
    chk(found == 1, "R3 waiting instruction granted", found, 1);
    @(negedge clk_i);
    ins_req_i[0] = 1'b0;
    chk(add_req_o[0] && add_a_o[WW-1:0] == IA, "R3 instruction issued after grant",
        add_a_o[WW-1:0], IA);
    repeat (30) @(negedge clk_i);
    hart_busy_i = '0;
    repeat (15) @(negedge clk_i);
    chk(n_disp == 1, "R6 displaced instruction counted", n_disp, 1);
    chk(n_coinc > 0, "R7 coincident completions seen", n_coinc, 1);
    check_count("R7 count sums coincident completions", exp_cnt);

    // R9 consistent split reads while counting, R8 wrap
    for (int k = 0; k < NA; k++) lat[k] = 1;
    hart_busy_i = 2'b11;
    for (int j = 0; j < 8; j++) begin
      repeat (17) @(negedge clk_i);
      snap = exp_cnt;
      rd(1'b1, d);
      chk(d == snap[CW-1:WW], "R9 high word", d, snap[CW-1:WW]);
      repeat (3) @(negedge clk_i);
      rd(1'b0, d);
      chk(d == snap[WW-1:0], "R9 captured low word", d, snap[WW-1:0]);
      snap = exp_cnt;
      rd(1'b0, d);
      chk(d == snap[WW-1:0], "R9 live low word", d, snap[WW-1:0]);
    end
    for (int i = 0; i < 2000 && n_tot < 300; i++) @(negedge clk_i);
    hart_busy_i = '0;
    repeat (10) @(negedge clk_i);
    chk(n_tot > 255, "R8 wrap reached", n_tot, 256);
    check_count("R8 count modulo 2^CW", CW'(n_tot % 256));

    // R8 reset clears
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_count("R8 count cleared by reset", '0);

    summary();
    $finish;
  end
endmodule